// File: doc/BRIEF.md
# Two-Layer Windowed Pixel Compositor

This block sits in the pixel clock domain of a display path. On every pixel clock it receives the screen coordinate of the current pixel and one ARGB8888 sample from each of two layers. It produces one 24-bit RGB result. The compositor stacks the layers in a fixed order over a solid background colour: the background is at the bottom, layer 1 is above it and layer 2 is on top. Each stage mixes its layer into the colour beneath it using a per-layer blend factor.

Each layer has the following controls:
- an enable;
- an inclusive rectangular window given in columns and lines;
- a default ARGB colour, used outside the window or when the layer is off;
- a colour key with its own enable;
- an 8-bit constant alpha;
- a factor mode that uses either the constant alpha alone or the pixel alpha scaled by the constant alpha.

All controls are sampled together with the pixel they apply to, so they can change while a frame is running. Fetching the layer data, converting its format, generating the timing signals and dithering the output happen elsewhere. The data-enable and sync strobes pass through the same number of stages as the pixels, so they stay aligned with the output.

Top module: `two_layer_compositor`

## Requirements
- R1: The stacking order is fixed. The background is at the bottom, layer 1 is blended over it, and layer 2 is blended over that result. Layer index 0 on each packed layer port is layer 1 and index 1 is layer 2.
- R2: A layer is inside its window when first column <= x <= last column and first line <= y <= last line. Both bounds are inclusive. If a last bound is below its first bound, the window is empty and the layer always uses its default colour.
- R3: When a layer is disabled, or the coordinate is outside its window, the layer's selected ARGB value is its default colour and not the pixel input.
- R4: When keying is enabled and the RGB part of a layer's selected colour (bits 23:0) equals that layer's key, the selected colour becomes 0 in all four channels (A, R, G and B) before the blend factor is formed.
- R5: Factor mode 0 uses the constant alpha as the blend factor. Factor mode 1 uses round(A*C/255), where A is the alpha (bits 31:24) of the selected colour and C is the constant alpha.
- R6: For each channel, a stage computes round((f*top + (255-f)*below)/255), with ties impossible, using the same rounding as the factor multiply. With f=255 the stage passes the layer colour through. With f=0 it passes the colour below through.
- R7: A disabled layer whose default colour is 0xFF000000 and whose constant alpha is 0xFF hides everything below it and gives black. With a default alpha of 0 in factor mode 1, that layer leaves the colour below unchanged.
- R8: The RGB output, data-enable and both syncs appear exactly three pixel clocks after their inputs are sampled, and they stay aligned with each other.
- R9: Enables, keys, key enables, windows, factors and the background take effect from the pixel sampled on the same clock. Toggling them on every pixel gives a correct result for every pixel.
- R10: While the synchronous active-high reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_de | input | 1 | Data-enable aligned with the input pixel |
| in_hs | input | 1 | Horizontal sync aligned with the input pixel |
| in_vs | input | 1 | Vertical sync aligned with the input pixel |
| pos_x | input | COORD_W | Column of the current pixel |
| pos_y | input | COORD_W | Line of the current pixel |
| lyr_pix | input | 2x32 | ARGB8888 sample per layer, A in bits 31:24 |
| lyr_en | input | 2 | Layer enable per layer |
| win_col_lo | input | 2xCOORD_W | First visible column per layer |
| win_col_hi | input | 2xCOORD_W | Last visible column per layer |
| win_row_lo | input | 2xCOORD_W | First visible line per layer |
| win_row_hi | input | 2xCOORD_W | Last visible line per layer |
| lyr_dflt | input | 2x32 | Default ARGB colour per layer |
| key_en | input | 2 | Colour-key enable per layer |
| key_rgb | input | 2x24 | Key colour per layer, R in bits 23:16 |
| const_alpha | input | 2x8 | Constant alpha per layer |
| fac_mode | input | 2 | 0: constant alpha; 1: pixel alpha scaled by constant alpha |
| bg_rgb | input | 24 | Background colour |
| out_de | output | 1 | Delayed data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Composited colour, R in bits 23:16 |

## Verification
The bench runs a behavioural reference model and compares its result with the outputs on every pixel clock, using the following input patterns:
- Coordinate sweeps across the edges of a small window, including an inverted window. These separate an off-by-one in either bound from correct inclusive clipping.
- Fully random pixels, alphas and factor modes. These exercise the rounding of both multiplies and the blend order.
- Targeted key matches and misses. These show whether all four channels are cleared, including the alpha, which only changes the result in factor mode 1.
- The opaque-black and transparent default cases, plus controls toggled on every pixel. These distinguish per-pixel sampling from any stale or staggered control path.

// File: rtl/comp_pkg.sv
package comp_pkg;

    localparam int CH_W  = 8;
    localparam int LAYERS = 2;
    localparam int LAT   = 3;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic {
        FAC_CONST     = 1'b0,
        FAC_PIX_CONST = 1'b1
    } fac_mode_e;

    typedef struct packed {
        rgb_t            c;
        logic [CH_W-1:0] f;
    } blend_src_t;

    // Rounded division by 255 of a value up to 255*255.
    function automatic logic [CH_W-1:0] div255(input logic [15:0] x);
        logic [16:0] t;
        logic [16:0] s;
        t = {1'b0, x} + 17'd128;
        s = (t + (t >> 8)) >> 8;
        return s[CH_W-1:0];
    endfunction

    function automatic logic [CH_W-1:0] mul8(input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] b);
        return div255(16'(a) * 16'(b));
    endfunction

    function automatic logic [CH_W-1:0] mix8(input logic [CH_W-1:0] f,
                                             input logic [CH_W-1:0] top,
                                             input logic [CH_W-1:0] bot);
        logic [15:0] inv;
        inv = 16'(8'd255 - f);
        return div255(16'(f) * 16'(top) + inv * 16'(bot));
    endfunction

    function automatic rgb_t mix_rgb(input logic [CH_W-1:0] f,
                                     input rgb_t top, input rgb_t bot);
        rgb_t o;
        o.r = mix8(f, top.r, bot.r);
        o.g = mix8(f, top.g, bot.g);
        o.b = mix8(f, top.b, bot.b);
        return o;
    endfunction

endpackage

// File: rtl/comp_layer_select.sv
module comp_layer_select
    import comp_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  argb_t              pix,
    input  logic               en,
    input  logic [COORD_W-1:0] col_lo,
    input  logic [COORD_W-1:0] col_hi,
    input  logic [COORD_W-1:0] row_lo,
    input  logic [COORD_W-1:0] row_hi,
    input  argb_t              dflt,
    input  logic               key_on,
    input  rgb_t               key,
    input  logic [CH_W-1:0]    calpha,
    input  fac_mode_e          mode,
    output blend_src_t         src
);

    logic            in_win;
    argb_t           chosen;
    argb_t           keyed;
    logic [CH_W-1:0] fac;
    argb_t           sel_q;
    logic [CH_W-1:0] fac_q;

    always_comb begin
        in_win = (x >= col_lo) && (x <= col_hi) && (y >= row_lo) && (y <= row_hi);
        chosen = (en && in_win) ? pix : dflt;
        keyed  = (key_on && (chosen[23:0] == key)) ? '0 : chosen;
        fac    = (mode == FAC_CONST) ? calpha : mul8(keyed.a, calpha);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            fac_q <= '0;
        end else begin
            sel_q <= keyed;
            fac_q <= fac;
        end
    end

    assign src.c = sel_q[23:0];
    assign src.f = fac_q;

    AST_KEY_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
        (key_on && en && in_win && (pix[23:0] == key)) |=> (sel_q == '0)); // R4

    AST_DISABLED_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (!en && !(key_on && (dflt[23:0] == key))) |=> (sel_q == $past(dflt))); // R3

    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ((col_hi < col_lo) && !(key_on && (dflt[23:0] == key))) |=> (sel_q == $past(dflt))); // R2

    AST_CONST_FACTOR: assert property (@(posedge clk) disable iff (rst)
        (mode == FAC_CONST) |=> (fac_q == $past(calpha))); // R5

endmodule

// File: rtl/comp_blend_stage.sv
module comp_blend_stage
    import comp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  blend_src_t top,
    input  rgb_t       below,
    output rgb_t       mixed
);

    rgb_t mixed_q;

    always_ff @(posedge clk) begin
        if (rst) mixed_q <= '0;
        else     mixed_q <= mix_rgb(top.f, top.c, below);
    end

    assign mixed = mixed_q;

    AST_OPAQUE_PASSES_TOP: assert property (@(posedge clk) disable iff (rst)
        (top.f == 8'd255) |=> (mixed_q == $past(top.c))); // R6

    AST_CLEAR_PASSES_BELOW: assert property (@(posedge clk) disable iff (rst)
        (top.f == 8'd0) |=> (mixed_q == $past(below))); // R6

endmodule

// File: rtl/two_layer_compositor.sv
module two_layer_compositor
    import comp_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_de,
    input  logic                             in_hs,
    input  logic                             in_vs,
    input  logic [COORD_W-1:0]               pos_x,
    input  logic [COORD_W-1:0]               pos_y,
    input  logic [LAYERS-1:0][31:0]          lyr_pix,
    input  logic [LAYERS-1:0]                lyr_en,
    input  logic [LAYERS-1:0][COORD_W-1:0]   win_col_lo,
    input  logic [LAYERS-1:0][COORD_W-1:0]   win_col_hi,
    input  logic [LAYERS-1:0][COORD_W-1:0]   win_row_lo,
    input  logic [LAYERS-1:0][COORD_W-1:0]   win_row_hi,
    input  logic [LAYERS-1:0][31:0]          lyr_dflt,
    input  logic [LAYERS-1:0]                key_en,
    input  logic [LAYERS-1:0][23:0]          key_rgb,
    input  logic [LAYERS-1:0][7:0]           const_alpha,
    input  logic [LAYERS-1:0]                fac_mode,
    input  logic [23:0]                      bg_rgb,
    output logic                             out_de,
    output logic                             out_hs,
    output logic                             out_vs,
    output logic [23:0]                      out_rgb
);

    localparam int SYNC_W = 3;

    blend_src_t src [LAYERS];
    rgb_t       bg_q;
    blend_src_t upper_q;
    rgb_t       mid_rgb;
    rgb_t       fin_rgb;

    // Stage 1: per-layer selection, keying and factor
    for (genvar i = 0; i < LAYERS; i++) begin : g_layer
        comp_layer_select #(.COORD_W(COORD_W)) u_sel (
            .clk    (clk),
            .rst    (rst),
            .x      (pos_x),
            .y      (pos_y),
            .pix    (argb_t'(lyr_pix[i])),
            .en     (lyr_en[i]),
            .col_lo (win_col_lo[i]),
            .col_hi (win_col_hi[i]),
            .row_lo (win_row_lo[i]),
            .row_hi (win_row_hi[i]),
            .dflt   (argb_t'(lyr_dflt[i])),
            .key_on (key_en[i]),
            .key    (rgb_t'(key_rgb[i])),
            .calpha (const_alpha[i]),
            .mode   (fac_mode_e'(fac_mode[i])),
            .src    (src[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bg_q    <= '0;
            upper_q <= '0;
        end else begin
            bg_q    <= rgb_t'(bg_rgb);
            upper_q <= src[1];
        end
    end

    // Stage 2: layer 1 over background
    comp_blend_stage u_lower (
        .clk   (clk),
        .rst   (rst),
        .top   (src[0]),
        .below (bg_q),
        .mixed (mid_rgb)
    );

    // Stage 3: layer 2 over stage 2 result
    comp_blend_stage u_upper (
        .clk   (clk),
        .rst   (rst),
        .top   (upper_q),
        .below (mid_rgb),
        .mixed (fin_rgb)
    );

    assign out_rgb = fin_rgb;

    // Strobe delay matching the pixel pipeline
    logic [SYNC_W-1:0] sync_pipe [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_pipe[s] <= '0;
            else if (s == 0) sync_pipe[s] <= {in_de, in_hs, in_vs};
            else sync_pipe[s] <= sync_pipe[(s == 0) ? 0 : s-1];
        end
    end

    assign {out_de, out_hs, out_vs} = sync_pipe[LAT-1];

    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst) warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd3) |-> ({out_de, out_hs, out_vs} == $past({in_de, in_hs, in_vs}, 3))); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (out_rgb == '0 && !out_de && !out_hs && !out_vs)); // R10

endmodule

// File: tb/two_layer_compositor_bench.sv
module two_layer_compositor_bench;

    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic in_de, in_hs, in_vs;
    logic [CW-1:0] pos_x, pos_y;
    logic [1:0][31:0] lyr_pix;
    logic [1:0] lyr_en;
    logic [1:0][CW-1:0] win_col_lo, win_col_hi, win_row_lo, win_row_hi;
    logic [1:0][31:0] lyr_dflt;
    logic [1:0] key_en;
    logic [1:0][23:0] key_rgb;
    logic [1:0][7:0] const_alpha;
    logic [1:0] fac_mode;
    logic [23:0] bg_rgb;
    logic out_de, out_hs, out_vs;
    logic [23:0] out_rgb;

    two_layer_compositor #(.COORD_W(CW)) u_two_layer_compositor (
        .clk(clk), .rst(rst), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
        .pos_x(pos_x), .pos_y(pos_y), .lyr_pix(lyr_pix), .lyr_en(lyr_en),
        .win_col_lo(win_col_lo), .win_col_hi(win_col_hi),
        .win_row_lo(win_row_lo), .win_row_hi(win_row_hi),
        .lyr_dflt(lyr_dflt), .key_en(key_en), .key_rgb(key_rgb),
        .const_alpha(const_alpha), .fac_mode(fac_mode), .bg_rgb(bg_rgb),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [26:0] exp_q[$];
    string       tag_q[$];

    function automatic int rdiv(int v);
        return (v + 127) / 255;
    endfunction

    // Reference: behavioural per-channel integer model
    function automatic logic [23:0] model();
        int ch[3];
        ch[0] = int'(bg_rgb[23:16]);
        ch[1] = int'(bg_rgb[15:8]);
        ch[2] = int'(bg_rgb[7:0]);
        for (int i = 0; i < 2; i++) begin
            logic [31:0] c;
            int f;
            bit inside_w;
            inside_w = (pos_x >= win_col_lo[i]) && (pos_x <= win_col_hi[i]) &&
                       (pos_y >= win_row_lo[i]) && (pos_y <= win_row_hi[i]);
            c = (lyr_en[i] && inside_w) ? lyr_pix[i] : lyr_dflt[i];
            if (key_en[i] && c[23:0] == key_rgb[i]) c = 32'h0;
            f = fac_mode[i] ? rdiv(int'(c[31:24]) * int'(const_alpha[i])) : int'(const_alpha[i]);
            for (int k = 0; k < 3; k++) begin
                int top;
                top = int'(c[23 - 8*k -: 8]);
                ch[k] = rdiv(f * top + (255 - f) * ch[k]);
            end
        end
        return {ch[0][7:0], ch[1][7:0], ch[2][7:0]};
    endfunction

    task automatic check_out(string tag, logic [26:0] exp);
        checks++;
        if (out_rgb !== exp[23:0]) begin
            errors++;
            $display("FAIL %s rgb actual=%06h expected=%06h", tag, out_rgb, exp[23:0]);
        end
        checks++;
        if ({out_de, out_hs, out_vs} !== exp[26:24]) begin
            errors++;
            $display("FAIL R8 strobes actual=%03b expected=%03b", {out_de, out_hs, out_vs}, exp[26:24]);
        end
    endtask

    // Push expectation for current inputs, advance one pixel, compare the due entry
    task automatic step(string tag);
        exp_q.push_back({in_de, in_hs, in_vs, model()});
        tag_q.push_back(tag);
        @(negedge clk);
        if (exp_q.size() == 3) check_out(tag_q.pop_front(), exp_q.pop_front());
        in_de = 1'($urandom); in_hs = 1'($urandom); in_vs = 1'($urandom);
    endtask

    task automatic base_cfg();
        for (int i = 0; i < 2; i++) begin
            lyr_en[i] = 1'b1;
            win_col_lo[i] = '0; win_col_hi[i] = '1;
            win_row_lo[i] = '0; win_row_hi[i] = '1;
            lyr_dflt[i] = 32'h0;
            key_en[i] = 1'b0;
            key_rgb[i] = 24'h0;
            const_alpha[i] = 8'hFF;
            fac_mode[i] = 1'b1;
        end
        bg_rgb = $urandom;
    endtask

    task automatic rand_pix();
        lyr_pix[0] = $urandom;
        lyr_pix[1] = $urandom;
        pos_x = CW'($urandom);
        pos_y = CW'($urandom);
    endtask

    initial begin
        in_de = 0; in_hs = 0; in_vs = 0;
        pos_x = '0; pos_y = '0; lyr_pix = '0;
        base_cfg();
        rand_pix();
        // R10: outputs held at zero during reset
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            checks++;
            if (out_rgb !== 24'h0 || {out_de, out_hs, out_vs} !== 3'b000) begin
                errors++;
                $display("FAIL R10 actual=%06h/%03b expected=000000/000", out_rgb, {out_de, out_hs, out_vs});
            end
        end
        rst = 1'b0;

        // R1: fixed stacking order with opaque layers
        lyr_pix[0] = 32'hFFFF0000; lyr_pix[1] = 32'hFF0000FF;
        step("R1");
        lyr_en[1] = 1'b0; lyr_dflt[1] = 32'h00000000;
        step("R1");
        lyr_en[0] = 1'b0; lyr_dflt[0] = 32'h0;
        step("R1");
        lyr_en = 2'b11; lyr_pix[0] = 32'hFF00FF00; lyr_pix[1] = 32'h80FF00FF;
        for (int n = 0; n < 6; n++) step("R1");

        // R2: inclusive window edges and an inverted window
        base_cfg();
        lyr_en[1] = 1'b0;
        win_col_lo[0] = 12'd3; win_col_hi[0] = 12'd5;
        win_row_lo[0] = 12'd2; win_row_hi[0] = 12'd4;
        lyr_dflt[0] = 32'h80112233;
        for (int yy = 1; yy <= 5; yy++)
            for (int xx = 1; xx <= 7; xx++) begin
                pos_x = CW'(xx); pos_y = CW'(yy);
                lyr_pix[0] = $urandom | 32'hFF000000;
                step("R2");
            end
        win_col_lo[0] = 12'd6; win_col_hi[0] = 12'd5;
        for (int n = 0; n < 10; n++) begin
            pos_x = CW'(n); pos_y = 12'd3;
            lyr_pix[0] = $urandom;
            step("R2");
        end

        // R3: disabled layers show their default colour
        base_cfg();
        for (int n = 0; n < 24; n++) begin
            rand_pix();
            lyr_en = 2'($urandom);
            lyr_dflt[0] = $urandom; lyr_dflt[1] = $urandom;
            fac_mode = 2'($urandom);
            step("R3");
        end

        // R4: key matches clear all four channels
        base_cfg();
        key_en = 2'b11;
        for (int n = 0; n < 40; n++) begin
            rand_pix();
            key_rgb[0] = $urandom; key_rgb[1] = $urandom;
            if (n % 2 == 0) lyr_pix[0][23:0] = key_rgb[0];
            if (n % 3 == 0) lyr_pix[1][23:0] = key_rgb[1];
            const_alpha[0] = $urandom; const_alpha[1] = $urandom;
            fac_mode = 2'($urandom);
            step("R4");
        end

        // R5: constant-only factor ignores pixel alpha
        base_cfg();
        fac_mode = 2'b00;
        for (int n = 0; n < 30; n++) begin
            rand_pix();
            const_alpha[0] = $urandom; const_alpha[1] = $urandom;
            step("R5");
        end

        // R6: random mixing with rounding
        base_cfg();
        for (int n = 0; n < 400; n++) begin
            rand_pix();
            const_alpha[0] = $urandom; const_alpha[1] = $urandom;
            fac_mode = 2'($urandom);
            bg_rgb = $urandom;
            step("R6");
        end
        const_alpha = '0;
        for (int n = 0; n < 4; n++) begin rand_pix(); step("R6"); end

        // R7: opaque black default covers; transparent default bypasses
        base_cfg();
        lyr_pix[0] = 32'hFF3366CC;
        lyr_en[1] = 1'b0; lyr_dflt[1] = 32'hFF000000; const_alpha[1] = 8'hFF;
        fac_mode[1] = 1'b0;
        for (int n = 0; n < 4; n++) step("R7");
        lyr_dflt[1] = 32'h00000000; fac_mode[1] = 1'b1;
        for (int n = 0; n < 4; n++) step("R7");

        // R9: controls toggled on every pixel
        base_cfg();
        for (int n = 0; n < 60; n++) begin
            rand_pix();
            key_rgb[1] = lyr_pix[1][23:0];
            key_en = 2'($urandom);
            lyr_en = 2'($urandom);
            lyr_dflt[0] = $urandom; lyr_dflt[1] = $urandom;
            fac_mode = 2'($urandom);
            bg_rgb = $urandom;
            step("R9");
        end

        for (int n = 0; n < 3; n++) step("R8");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule